// File: doc/BRIEF.md
# Accumulator Execution Core with Compare and Carry Status

This block is the datapath heart of a small accumulator machine. It holds an accumulator (A), a second operand register (B), a four-bit operation register (C) that selects what the combinational ALU computes, and a four-bit status register. An external sequencer drives one-cycle strobes that load the accumulator from one of four sources, clear it, copy it into B or C, and capture status. The ALU result and the status register are the block's outputs.

The operation to perform is not decoded from an instruction. Software first places an operation code in the accumulator and copies it into C. That code then selects the ALU function for every later cycle until C is written again. The status register records the unsigned ordering of A against B and the carry or borrow of the selected operation. Conditional branching elsewhere in the machine relies on it.

Top module: `accx_exec_core`

## Requirements
- R1: After reset, A, B, C and the status register are all zero, so `alu_result` reads 0 and `status` reads 0.
- R2: When `ld_a` is high at a rising edge, A takes the value picked by `a_src`: 0 selects the current ALU result, 1 selects `in_port`, 2 selects `imm_byte` and 3 selects `ram_rdata`.
- R3: When `clr_a` is high at a rising edge, A becomes zero. This holds even if `ld_a` is high at the same edge.
- R4: `cp_b` copies A into B. `cp_c` copies the low four bits of A into C. Neither strobe changes A.
- R5: The arithmetic codes in C work modulo 256: 0000 passes A, 0001 gives A+1, 0010 gives A+B and 0011 gives A-B.
- R6: The bitwise codes in C are: 0100 AND, 0101 OR, 0110 XOR, 0111 NAND, 1000 NOR, 1001 XNOR, and 1010 inverts A.
- R7: The shift codes in C are: 1011 shifts A left, 1100 shifts A right, 1101 rotates A left and 1110 rotates A right. Plain shifts fill the vacated bit with zero. Code 1111 passes A.
- R8: On an edge where `upd_flags` is high, the status register captures three unsigned compare flags from the A and B held before that edge: bit 0 is A<B, bit 1 is A>B and bit 2 is A=B. The status register holds its value on every other edge.
- R9: Status bit 3, captured with the compare flags, is set in three cases: the carry out of A+B, an increment of 0xFF, and the borrow of A-B when A<B. It is 0 for every other code.
- R10: `alu_result` is combinational from the registered A, B and C. It reflects a register load from the first sample after the loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_a | input | 1 | Load accumulator from the selected source |
| a_src | input | 2 | Accumulator source select (0 ALU, 1 port, 2 immediate, 3 RAM) |
| clr_a | input | 1 | Clear accumulator; wins over `ld_a` |
| cp_b | input | 1 | Copy accumulator into B |
| cp_c | input | 1 | Copy accumulator low nibble into C |
| upd_flags | input | 1 | Capture compare flags and carry |
| in_port | input | 8 | Input register value |
| imm_byte | input | 8 | Immediate byte from the instruction |
| ram_rdata | input | 8 | RAM read data |
| alu_result | output | 8 | Combinational ALU output |
| status | output | 4 | {carry, A=B, A>B, A<B} |

## Verification
A wrong accumulator value is visible on `alu_result` in the very next sample whenever C selects pass-through. A wrong B or C stays hidden until an operation that uses it is selected, so the bench programs C and B explicitly before it observes each result. A corrupted status register appears only one edge after an `upd_flags` strobe, and then it persists. The bench therefore checks both the captured value and that the value is held across later loads of A.

// File: rtl/accx_pkg.sv
package accx_pkg;

   typedef enum logic [3:0] {
      OP_PASS  = 4'd0,
      OP_INC   = 4'd1,
      OP_ADD   = 4'd2,
      OP_SUB   = 4'd3,
      OP_AND   = 4'd4,
      OP_OR    = 4'd5,
      OP_XOR   = 4'd6,
      OP_NAND  = 4'd7,
      OP_NOR   = 4'd8,
      OP_XNOR  = 4'd9,
      OP_NOT   = 4'd10,
      OP_SHL   = 4'd11,
      OP_SHR   = 4'd12,
      OP_ROL   = 4'd13,
      OP_ROR   = 4'd14,
      OP_SPARE = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      SRC_ALU  = 2'd0,
      SRC_PORT = 2'd1,
      SRC_IMM  = 2'd2,
      SRC_RAM  = 2'd3
   } a_src_e;

   localparam int OP_W    = 4;
   localparam int FLAG_W  = 4;
   localparam int FLAG_LT = 0;
   localparam int FLAG_GT = 1;
   localparam int FLAG_EQ = 2;
   localparam int FLAG_CY = 3;

   function automatic logic op_has_carry(alu_op_e op);
      return (op == OP_INC) || (op == OP_ADD) || (op == OP_SUB);
   endfunction

endpackage

// File: rtl/accx_amux.sv
module accx_amux
   import accx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  a_src_e              sel_i,
   input  logic [DATA_W-1:0]   alu_i,
   input  logic [DATA_W-1:0]   port_i,
   input  logic [DATA_W-1:0]   imm_i,
   input  logic [DATA_W-1:0]   ram_i,
   output logic [DATA_W-1:0]   d_o
);

   always_comb begin
      unique case (sel_i)
         SRC_ALU:  d_o = alu_i;
         SRC_PORT: d_o = port_i;
         SRC_IMM:  d_o = imm_i;
         SRC_RAM:  d_o = ram_i;
         default:  d_o = alu_i;
      endcase
   end

endmodule

// File: rtl/accx_alu.sv
module accx_alu
   import accx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  alu_op_e           op_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cy_o
);

   localparam int SUM_W = DATA_W + 1;
   localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

   logic [DATA_W-1:0] arith_res;
   logic              arith_cy;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("accx_alu: DATA_W must be at least 2");
      end

      if (SHARED_ADDER) begin : g_shared
         // One carry chain: subtraction adds ~B plus one, increment adds zero plus one.
         logic [DATA_W-1:0] rhs;
         logic              cin;
         logic [SUM_W-1:0]  sum;

         always_comb begin
            rhs = b_i;
            cin = 1'b0;
            if (op_i == OP_SUB) begin
               rhs = ~b_i;
               cin = 1'b1;
            end else if (op_i == OP_INC) begin
               rhs = '0;
               cin = 1'b1;
            end
            sum = {1'b0, a_i} + {1'b0, rhs} + {{DATA_W{1'b0}}, cin};
         end

         assign arith_res = sum[DATA_W-1:0];
         // A carry out of A + ~B + 1 means no borrow.
         assign arith_cy  = (op_i == OP_SUB) ? ~sum[DATA_W] : sum[DATA_W];
      end else begin : g_split
         // Three independent chains, selected afterwards.
         logic [SUM_W-1:0] s_inc;
         logic [SUM_W-1:0] s_add;
         logic [SUM_W-1:0] s_sub;

         assign s_inc = {1'b0, a_i} + ONE;
         assign s_add = {1'b0, a_i} + {1'b0, b_i};
         assign s_sub = {1'b0, a_i} - {1'b0, b_i};

         always_comb begin
            unique case (op_i)
               OP_INC: begin
                  arith_res = s_inc[DATA_W-1:0];
                  arith_cy  = s_inc[DATA_W];
               end
               OP_SUB: begin
                  arith_res = s_sub[DATA_W-1:0];
                  arith_cy  = s_sub[DATA_W];
               end
               default: begin
                  arith_res = s_add[DATA_W-1:0];
                  arith_cy  = s_add[DATA_W];
               end
            endcase
         end
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_PASS:  res_o = a_i;
         OP_INC:   res_o = arith_res;
         OP_ADD:   res_o = arith_res;
         OP_SUB:   res_o = arith_res;
         OP_AND:   res_o = a_i & b_i;
         OP_OR:    res_o = a_i | b_i;
         OP_XOR:   res_o = a_i ^ b_i;
         OP_NAND:  res_o = ~(a_i & b_i);
         OP_NOR:   res_o = ~(a_i | b_i);
         OP_XNOR:  res_o = ~(a_i ^ b_i);
         OP_NOT:   res_o = ~a_i;
         OP_SHL:   res_o = {a_i[DATA_W-2:0], 1'b0};
         OP_SHR:   res_o = {1'b0, a_i[DATA_W-1:1]};
         OP_ROL:   res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
         OP_ROR:   res_o = {a_i[0], a_i[DATA_W-1:1]};
         OP_SPARE: res_o = a_i;
         default:  res_o = a_i;
      endcase
      cy_o = op_has_carry(op_i) ? arith_cy : 1'b0;
   end

endmodule

// File: rtl/accx_status.sv
module accx_status
   import accx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  alu_op_e           op_i,
   input  logic              cy_i,
   output logic [FLAG_W-1:0] flags_o
);

   logic [FLAG_W-1:0] flags_d;

   always_comb begin
      flags_d          = '0;
      flags_d[FLAG_LT] = (a_i <  b_i);
      flags_d[FLAG_GT] = (a_i >  b_i);
      flags_d[FLAG_EQ] = (a_i == b_i);
      flags_d[FLAG_CY] = cy_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_o <= '0;
      end else if (upd_i) begin
         flags_o <= flags_d;
      end
   end

   // R8
   cmp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> ($countones(flags_o[FLAG_EQ:FLAG_LT]) == 1));

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(flags_o));

   // R9
   carry_only_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !op_has_carry(op_i)) |=> !flags_o[FLAG_CY]);

endmodule

// File: rtl/accx_exec_core.sv
module accx_exec_core
   import accx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_a,
   input  logic [1:0]        a_src,
   input  logic              clr_a,
   input  logic              cp_b,
   input  logic              cp_c,
   input  logic              upd_flags,
   input  logic [DATA_W-1:0] in_port,
   input  logic [DATA_W-1:0] imm_byte,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] alu_result,
   output logic [3:0]        status
);

   generate
      if (DATA_W < OP_W) begin : g_bad_width
         $error("accx_exec_core: DATA_W must hold an operation code");
      end
   endgenerate

   logic [DATA_W-1:0] a_q;
   logic [DATA_W-1:0] b_q;
   alu_op_e           c_q;
   logic [DATA_W-1:0] a_next;
   logic [DATA_W-1:0] res;
   logic              res_cy;

   accx_amux #(.DATA_W(DATA_W)) u_amux (
      .sel_i  (a_src_e'(a_src)),
      .alu_i  (res),
      .port_i (in_port),
      .imm_i  (imm_byte),
      .ram_i  (ram_rdata),
      .d_o    (a_next)
   );

   accx_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .a_i   (a_q),
      .b_i   (b_q),
      .op_i  (c_q),
      .res_o (res),
      .cy_o  (res_cy)
   );

   accx_status #(.DATA_W(DATA_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_i   (upd_flags),
      .a_i     (a_q),
      .b_i     (b_q),
      .op_i    (c_q),
      .cy_i    (res_cy),
      .flags_o (status)
   );

   // Accumulator: clear wins over load.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
      end else if (clr_a) begin
         a_q <= '0;
      end else if (ld_a) begin
         a_q <= a_next;
      end
   end

   // Operand and operation registers are fed only from the accumulator.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_q <= '0;
         c_q <= OP_PASS;
      end else begin
         if (cp_b) b_q <= a_q;
         if (cp_c) c_q <= alu_op_e'(a_q[OP_W-1:0]);
      end
   end

   assign alu_result = res;

   // R3
   a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_a |=> (a_q == '0));

   // R2
   a_port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_a && !clr_a && a_src == SRC_PORT) |=> (a_q == $past(in_port)));

   // R4
   b_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cp_b |=> (b_q == $past(a_q)));

   // R4
   a_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_a && !clr_a) |=> $stable(a_q));

endmodule

// File: tb/accx_exec_core_bench.sv
module accx_exec_core_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_a = 1'b0, clr_a = 1'b0, cp_b = 1'b0, cp_c = 1'b0, upd_flags = 1'b0;
   logic [1:0] a_src = 2'd0;
   logic [7:0] in_port = 8'h00, imm_byte = 8'h00, ram_rdata = 8'h00;
   logic [7:0] alu_result;
   logic [3:0] status;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   accx_exec_core u_accx_exec_core (
      .clk(clk), .rst_n(rst_n), .ld_a(ld_a), .a_src(a_src), .clr_a(clr_a),
      .cp_b(cp_b), .cp_c(cp_c), .upd_flags(upd_flags), .in_port(in_port),
      .imm_byte(imm_byte), .ram_rdata(ram_rdata),
      .alu_result(alu_result), .status(status)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] m_res(logic [3:0] op, logic [7:0] a, logic [7:0] b);
      case (op)
         4'd1:  return a + 8'd1;
         4'd2:  return a + b;
         4'd3:  return a - b;
         4'd4:  return a & b;
         4'd5:  return a | b;
         4'd6:  return a ^ b;
         4'd7:  return ~(a & b);
         4'd8:  return ~(a | b);
         4'd9:  return ~(a ^ b);
         4'd10: return ~a;
         4'd11: return {a[6:0], 1'b0};
         4'd12: return {1'b0, a[7:1]};
         4'd13: return {a[6:0], a[7]};
         4'd14: return {a[0], a[7:1]};
         default: return a;
      endcase
   endfunction

   function automatic logic [3:0] m_flags(logic [3:0] op, logic [7:0] a, logic [7:0] b);
      logic cy;
      case (op)
         4'd1: cy = (a == 8'hFF);
         4'd2: cy = ({1'b0, a} + {1'b0, b}) > 9'h0FF;
         4'd3: cy = (a < b);
         default: cy = 1'b0;
      endcase
      return {cy, a == b, a > b, a < b};
   endfunction

   // one strobe cycle: drive at negedge, hold across one rising edge
   task automatic load(logic [1:0] src, logic [7:0] v);
      @(negedge clk);
      ld_a = 1'b1; a_src = src;
      case (src)
         2'd1: in_port = v;
         2'd2: imm_byte = v;
         2'd3: ram_rdata = v;
         default: ;
      endcase
      @(negedge clk);
      ld_a = 1'b0;
   endtask

   task automatic copy_b();
      @(negedge clk); cp_b = 1'b1;
      @(negedge clk); cp_b = 1'b0;
   endtask

   task automatic copy_c();
      @(negedge clk); cp_c = 1'b1;
      @(negedge clk); cp_c = 1'b0;
   endtask

   task automatic update();
      @(negedge clk); upd_flags = 1'b1;
      @(negedge clk); upd_flags = 1'b0;
   endtask

   task automatic program_core(logic [3:0] op, logic [7:0] a, logic [7:0] b);
      load(2'd2, {4'h0, op});
      copy_c();
      load(2'd2, b);
      copy_b();
      load(2'd2, a);
   endtask

   task automatic t_reset();
      check("R1 result", alu_result, 8'h00);
      check("R1 status", {4'h0, status}, 8'h00);
   endtask

   task automatic t_mux();
      program_core(4'd0, 8'h00, 8'h00);
      load(2'd1, 8'h5A); check("R2 port", alu_result, 8'h5A);
      load(2'd2, 8'hC3); check("R2 imm", alu_result, 8'hC3);
      load(2'd3, 8'h81); check("R2 ram", alu_result, 8'h81);
      program_core(4'd1, 8'h10, 8'h00);
      load(2'd0, 8'h00); check("R2 alu feedback", alu_result, 8'h12);
   endtask

   task automatic t_clear();
      program_core(4'd0, 8'h77, 8'h00);
      @(negedge clk); clr_a = 1'b1; ld_a = 1'b1; a_src = 2'd2; imm_byte = 8'h99;
      @(negedge clk); clr_a = 1'b0; ld_a = 1'b0;
      check("R3 clear beats load", alu_result, 8'h00);
      load(2'd2, 8'h34);
      @(negedge clk); clr_a = 1'b1;
      @(negedge clk); clr_a = 1'b0;
      check("R3 clear alone", alu_result, 8'h00);
   endtask

   task automatic t_copy();
      program_core(4'd2, 8'h21, 8'h00);
      copy_b();
      check("R4 cp_b keeps A, B=A", alu_result, 8'h42);
      load(2'd2, 8'hF0);
      copy_c();
      check("R4 cp_c low nibble to C (pass)", alu_result, 8'hF0);
      load(2'd2, 8'hEB);
      copy_c();
      check("R4 cp_c selects shift left", alu_result, 8'hD6);
   endtask

   task automatic t_arith();
      logic [7:0] av [4] = '{8'h00, 8'h7F, 8'hFF, 8'h35};
      logic [7:0] bv [4] = '{8'h00, 8'h01, 8'h02, 8'h4A};
      for (int op = 0; op < 4; op++)
         for (int i = 0; i < 4; i++) begin
            program_core(op[3:0], av[i], bv[i]);
            check($sformatf("R5 op%0d", op), alu_result, m_res(op[3:0], av[i], bv[i]));
         end
   endtask

   task automatic t_logic();
      for (int op = 4; op <= 10; op++) begin
         program_core(op[3:0], 8'hC5, 8'h3C);
         check($sformatf("R6 op%0d", op), alu_result, m_res(op[3:0], 8'hC5, 8'h3C));
      end
   endtask

   task automatic t_shift();
      for (int op = 11; op <= 15; op++) begin
         program_core(op[3:0], 8'h81, 8'h00);
         check($sformatf("R7 op%0d a81", op), alu_result, m_res(op[3:0], 8'h81, 8'h00));
         load(2'd2, 8'h56);
         check($sformatf("R7 op%0d a56", op), alu_result, m_res(op[3:0], 8'h56, 8'h00));
      end
   endtask

   task automatic t_flags();
      logic [3:0] e;
      // compare ordering, logic op so carry is zero
      program_core(4'd4, 8'h10, 8'h20); update();
      check("R8 lt", {4'h0, status}, {4'h0, m_flags(4'd4, 8'h10, 8'h20)});
      program_core(4'd4, 8'hF0, 8'h20); update();
      check("R8 gt", {4'h0, status}, {4'h0, m_flags(4'd4, 8'hF0, 8'h20)});
      program_core(4'd4, 8'h33, 8'h33); update();
      check("R8 eq", {4'h0, status}, 8'h04);
      // hold while A changes
      load(2'd2, 8'h01);
      check("R8 hold", {4'h0, status}, 8'h04);
      // capture uses A before the edge that also loads A
      program_core(4'd0, 8'h80, 8'h40);
      @(negedge clk); upd_flags = 1'b1; ld_a = 1'b1; a_src = 2'd2; imm_byte = 8'h00;
      @(negedge clk); upd_flags = 1'b0; ld_a = 1'b0;
      check("R8 pre-edge A", {4'h0, status}, 8'h02);
      check("R10 A loaded same edge", alu_result, 8'h00);
      // carry cases
      program_core(4'd2, 8'hF0, 8'h20); update();
      e = m_flags(4'd2, 8'hF0, 8'h20);
      check("R9 add carry", {4'h0, status}, {4'h0, e});
      program_core(4'd1, 8'hFF, 8'h00); update();
      check("R9 inc carry", {4'h0, status}, {4'h0, m_flags(4'd1, 8'hFF, 8'h00)});
      program_core(4'd3, 8'h05, 8'h09); update();
      check("R9 sub borrow", {4'h0, status}, 8'h09);
      program_core(4'd3, 8'h09, 8'h05); update();
      check("R9 sub no borrow", {4'h0, status}, 8'h02);
      program_core(4'd11, 8'h80, 8'h00); update();
      check("R9 shift no carry", {4'h0, status}, 8'h02);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mux();
      t_clear();
      t_copy();
      t_arith();
      t_logic();
      t_shift();
      t_flags();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule